// File: doc/BRIEF.md
# Prescaled Match/Interval Timer Channel

This block is a single 16-bit timer channel. Its clock enable comes from an optional power-of-two prescaler. The count can run up or down. It either wraps over the full 16-bit range or stays within a programmed interval. Three comparators watch the count, and each one raises its own event when the count lands on its programmed value.

A register file outside the block supplies every setting as a static input: clock control, counter control, interval and the three match values. The block returns the current count and single-cycle event pulses for the interval wrap, the full-range overflow and each comparator. Interrupt status, bus decoding and the handling of pulses downstream are left to the surrounding logic.

Top module: `tmr_channel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count` is 0 and every event output is low.
- R2: With counting enabled, each count step raises `count` by one in up mode (cnt_ctrl bit 2 = 0). In full-range mode (cnt_ctrl bit 1 = 0), a step from 0xFFFF gives 0 and pulses `ev_overflow`.
- R3: When clk_ctrl bit 0 is 1, a step happens once every 2^(N+1) clocks, where N = clk_ctrl[4:1]. The first step comes on the 2^(N+1)-th clock after the prescaler phase is cleared. When clk_ctrl bit 0 is 0, a step happens on every clock.
- R4: While cnt_ctrl bit 0 is 1, `count` and the prescaler phase hold their values and no event pulses.
- R5: In interval mode (cnt_ctrl bit 1 = 1), an up step from the value on `interval` gives 0 and pulses `ev_interval`, while `ev_overflow` stays low. The count therefore passes through interval+1 states.
- R6: In down mode (cnt_ctrl bit 2 = 1), each step lowers `count` by one. A step from 0 reloads the wrap limit: `interval` in interval mode, or 0xFFFF otherwise. That step pulses `ev_interval` or `ev_overflow` to match the mode.
- R7: With match enable set (cnt_ctrl bit 3 = 1), `ev_match[i]` pulses in the cycle that `count` becomes the value of comparator i. Comparator i sits at bits [16*i+15:16*i] of `match_val`. This includes the value 0 reached through a wrap.
- R8: A comparator whose value is above the current wrap limit never pulses, and no comparator pulses while cnt_ctrl bit 3 is 0.
- R9: `cnt_clear` sets `count` and the prescaler phase to 0 on the next clock and overrides counting. It raises no event in that cycle.
- R10: Every event output is registered. It is high only in the cycle where the new count first shows, and low in the next cycle unless another step produces it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clear | input | 1 | Synchronous clear of count and prescaler phase |
| clk_ctrl | input | 5 | Bit 0 prescaler enable, bits [4:1] prescale exponent N |
| cnt_ctrl | input | 4 | Bit 0 halt, bit 1 interval mode, bit 2 down, bit 3 match enable |
| interval | input | 16 | Wrap limit in interval mode |
| match_val | input | 48 | Three 16-bit comparator values, comparator 0 in the low bits |
| count | output | 16 | Current count |
| ev_interval | output | 1 | Pulse on a wrap in interval mode |
| ev_overflow | output | 1 | Pulse on a wrap in full-range mode |
| ev_match | output | 3 | Per-comparator match pulses |

## Verification
Some rules hold on every cycle, and the in-module assertions check these. Without a step the count stays put, and a clear leaves zero with quiet events. The halt bit silences the prescaler. The two wrap events never coincide, and an overflow pulse never lasts two cycles. A comparator above the limit, or one with match enable off, stays silent. Other behaviour needs sequences with known expected values, so only the directed scenarios show it. This covers the exact prescaler period, the reload value after a down wrap, the interval+1 cycle length, a match reached through a wrap, and the 65536-step free-running overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int PSC_W   = 4;
  localparam int N_MATCH = 3;

  // counter-control word; packed member order gives bit positions 3..0
  typedef struct packed {
    logic match_en;   // bit 3
    logic down;       // bit 2
    logic int_mode;   // bit 1
    logic halt;       // bit 0
  } cnt_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             ps_en,
  input  logic [PSC_W-1:0] ps_exp,
  output logic             tick
);
  localparam int PH_W = 1 << PSC_W;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] mask;

  // N+1 low bits set: a tick when all of them are one
  assign mask = {PH_W{1'b1}} >> (PH_W - 1 - int'(ps_exp));

  always_comb begin
    if (!run)       tick = 1'b0;
    else if (ps_en) tick = ((phase & mask) == mask);
    else            tick = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          phase <= '0;
    else if (run && ps_en)   phase <= phase + 1'b1;
  end

  AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);  // R4
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(phase));  // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             down,
  input  logic             int_mode,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] nxt,
  output logic [CNT_W-1:0] limit,
  output logic             step,
  output logic             ev_interval,
  output logic             ev_overflow
);
  logic wrap;

  assign limit = int_mode ? interval : {CNT_W{1'b1}};
  assign step  = tick && !clr;

  always_comb begin
    wrap = 1'b0;
    if (down) begin
      if (count == '0) begin
        nxt  = limit;
        wrap = 1'b1;
      end else if (count > limit) begin
        nxt = limit;
      end else begin
        nxt = count - 1'b1;
      end
    end else begin
      if (count >= limit) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count       <= '0;
      ev_interval <= 1'b0;
      ev_overflow <= 1'b0;
    end else begin
      ev_interval <= 1'b0;
      ev_overflow <= 1'b0;
      if (tick) begin
        count       <= nxt;
        ev_interval <= wrap && int_mode;
        ev_overflow <= wrap && !int_mode;
      end
    end
  end

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(count));  // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && !ev_interval && !ev_overflow));  // R9
  AST_WRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_interval, ev_overflow}));  // R5
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    ev_overflow |=> !ev_overflow);  // R10
  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && !down && count >= limit) |=> (count == '0));  // R5
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     step,
  input  logic                     en,
  input  logic [CNT_W-1:0]         nxt,
  input  logic [CNT_W-1:0]         limit,
  input  logic [N_MATCH*CNT_W-1:0] match_val,
  output logic [N_MATCH-1:0]       ev_match
);
  for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
    logic [CNT_W-1:0] mv;
    logic             hit;

    assign mv  = match_val[i*CNT_W +: CNT_W];
    assign hit = step && en && (nxt == mv) && (mv <= limit);

    always_ff @(posedge clk) begin
      if (rst || clr) ev_match[i] <= 1'b0;
      else            ev_match[i] <= hit;
    end

    AST_MATCH_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (rst)
      (mv > limit) |=> !ev_match[i]);  // R8
    AST_MATCH_OFF: assert property (@(posedge clk) disable iff (rst)
      !en |=> !ev_match[i]);  // R8
    AST_MATCH_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
      !step |=> !ev_match[i]);  // R10
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PSC_W,
  parameter int NM = N_MATCH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clear,
  input  logic [PW:0]      clk_ctrl,
  input  logic [3:0]       cnt_ctrl,
  input  logic [CW-1:0]    interval,
  input  logic [NM*CW-1:0] match_val,
  output logic [CW-1:0]    count,
  output logic             ev_interval,
  output logic             ev_overflow,
  output logic [NM-1:0]    ev_match
);
  cnt_ctrl_t      ctl;
  logic           tick;
  logic           step;
  logic [CW-1:0]  nxt;
  logic [CW-1:0]  limit;

  assign ctl = cnt_ctrl_t'(cnt_ctrl);

  tmr_prescaler #(.PSC_W(PW)) u_psc (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clear),
    .run    (!ctl.halt),
    .ps_en  (clk_ctrl[0]),
    .ps_exp (clk_ctrl[PW:1]),
    .tick   (tick)
  );

  tmr_counter #(.CNT_W(CW)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .clr         (cnt_clear),
    .tick        (tick),
    .down        (ctl.down),
    .int_mode    (ctl.int_mode),
    .interval    (interval),
    .count       (count),
    .nxt         (nxt),
    .limit       (limit),
    .step        (step),
    .ev_interval (ev_interval),
    .ev_overflow (ev_overflow)
  );

  tmr_match #(.CNT_W(CW), .N_MATCH(NM)) u_match (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clear),
    .step      (step),
    .en        (ctl.match_en),
    .nxt       (nxt),
    .limit     (limit),
    .match_val (match_val),
    .ev_match  (ev_match)
  );

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cnt_ctrl[0] |=> (!ev_interval && !ev_overflow && ev_match == '0));  // R4
endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_clear = 1'b0;
  logic [4:0]  clk_ctrl = '0;
  logic [3:0]  cnt_ctrl = 4'b0001;
  logic [15:0] interval = '0;
  logic [47:0] match_val = '0;
  logic [15:0] count;
  logic        ev_interval, ev_overflow;
  logic [2:0]  ev_match;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_channel uut (
    .clk(clk), .rst(rst), .cnt_clear(cnt_clear), .clk_ctrl(clk_ctrl),
    .cnt_ctrl(cnt_ctrl), .interval(interval), .match_val(match_val),
    .count(count), .ev_interval(ev_interval), .ev_overflow(ev_overflow),
    .ev_match(ev_match)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // events packed as {ev_match, ev_overflow, ev_interval}
  function automatic logic [31:0] evs();
    return {27'd0, ev_match, ev_overflow, ev_interval};
  endfunction

  task automatic restart(input logic [3:0] ctl, input logic [4:0] cc);
    @(negedge clk);
    cnt_ctrl  = ctl;
    clk_ctrl  = cc;
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 count in reset", count, 0);
    chk("R1 events in reset", evs(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count after reset", count, 0);
    chk("R1 events after reset", evs(), 0);
  endtask

  task automatic t_up_plain();
    restart(4'b0000, 5'b00110); // prescaler off, exponent ignored
    repeat (5) @(negedge clk);
    chk("R2 R3 up count every clock", count, 5);
    chk("R10 no events mid-range", evs(), 0);
  endtask

  task automatic t_halt();
    restart(4'b0000, 5'b00000);
    repeat (3) @(negedge clk);
    cnt_ctrl = 4'b0001;
    repeat (4) begin
      @(negedge clk);
      chk("R4 halted count holds", count, 3);
      chk("R4 halted no events", evs(), 0);
    end
    cnt_ctrl = 4'b0000;
    @(negedge clk);
    chk("R4 resumes after halt", count, 4);
  endtask

  task automatic t_prescale();
    restart(4'b0000, 5'b00011); // enabled, N=1 -> every 4 clocks
    repeat (3) @(negedge clk);
    chk("R3 N=1 no step before 4 clocks", count, 0);
    @(negedge clk);
    chk("R3 N=1 step on 4th clock", count, 1);
    repeat (4) @(negedge clk);
    chk("R3 N=1 second step", count, 2);
    restart(4'b0000, 5'b00001); // N=0 -> every 2 clocks
    @(negedge clk);
    chk("R3 N=0 after 1 clock", count, 0);
    @(negedge clk);
    chk("R3 N=0 after 2 clocks", count, 1);
    restart(4'b0000, 5'b00101); // N=2 -> every 8 clocks
    repeat (7) @(negedge clk);
    chk("R3 N=2 after 7 clocks", count, 0);
    @(negedge clk);
    chk("R3 N=2 after 8 clocks", count, 1);
  endtask

  task automatic t_clear();
    restart(4'b0000, 5'b00011);
    repeat (6) @(negedge clk); // count 1, phase 2
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    chk("R9 clear zeroes count", count, 0);
    chk("R9 clear no events", evs(), 0);
    repeat (3) @(negedge clk);
    chk("R9 phase cleared, no early step", count, 0);
    @(negedge clk);
    chk("R9 phase cleared, step on 4th", count, 1);
  endtask

  task automatic t_interval_match();
    interval  = 16'd3;
    match_val = {16'd5, 16'd0, 16'd2};
    restart(4'b1010, 5'b00000);
    @(negedge clk);
    chk("R7 count 1", count, 1);
    chk("R7 no event at 1", evs(), 0);
    @(negedge clk);
    chk("R7 match0 at 2", evs(), 32'b00100);
    @(negedge clk);
    chk("R10 match pulse one cycle", evs(), 0);
    @(negedge clk);
    chk("R5 wrap to 0", count, 0);
    chk("R5 R7 interval event and match1 at 0", evs(), 32'b01001);
    @(negedge clk);
    chk("R10 interval pulse one cycle", evs(), 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (ev_match[2]) chk("R8 match above limit fired", 1, 0);
    end
    chk("R8 match above limit silent", {31'd0, ev_match[2]}, 0);
    restart(4'b0010, 5'b00000); // match enable off
    repeat (2) @(negedge clk);
    chk("R8 match disabled at 2", {29'd0, ev_match}, 0);
    repeat (2) @(negedge clk);
    chk("R8 match disabled at wrap", evs(), 32'b00001);
  endtask

  task automatic t_down();
    restart(4'b0100, 5'b00000);
    @(negedge clk);
    chk("R6 down wrap reload 0xFFFF", count, 16'hFFFF);
    chk("R6 down wrap overflow", evs(), 32'b00010);
    @(negedge clk);
    chk("R6 down decrement", count, 16'hFFFE);
    chk("R10 overflow one cycle", evs(), 0);
    interval = 16'd3;
    restart(4'b0110, 5'b00000);
    @(negedge clk);
    chk("R6 down interval reload", count, 3);
    chk("R6 down interval event", evs(), 32'b00001);
    @(negedge clk);
    chk("R6 down interval decrement", count, 2);
  endtask

  task automatic t_free_overflow();
    restart(4'b0000, 5'b00000);
    repeat (65535) @(negedge clk);
    chk("R2 reaches 0xFFFF", count, 16'hFFFF);
    chk("R2 no event at top", evs(), 0);
    @(negedge clk);
    chk("R2 full-range wrap", count, 0);
    chk("R2 overflow event", evs(), 32'b00010);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_up_plain();
        t_halt();
        t_prescale();
        t_clear();
        t_interval_match();
        t_down();
        t_free_overflow();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule